// File: doc/BRIEF.md
# Deadline-Guarded Cross-Criticality Mailbox

This block passes one payload per logical cycle from a best-effort producer to a consumer that works to a hard deadline. Each side has its own small register port. The producer stages a payload and its own cycle number in a buffer inside the block, then raises a ready flag. When the consumer's timebase pulses the deadline input, the block judges the ready flag as it stands at that clock edge, and only then. If the packet is there, the block copies it into a delivery register that only the consumer can read, and it pulses `on_time_o`. If it is not there, the block sets a timeout flag and pulses `late_o`, so the consumer falls back to its default path. The producer sees the timeout flag and abandons the packet: its later writes in that cycle are dropped.

The consumer never waits on the producer. A producer that has slipped a whole cycle behind is caught when a delivered packet carries a cycle number that differs from the consumer's own count. This sets a sticky error that software clears. A cycle-start strobe from the consumer's timebase opens each logical cycle with both flags low.

Each port takes requests with a valid/ready handshake. `*_req_ready` is always high, so a request is accepted in any clock where `*_req_valid` is high and no back-pressure is ever applied. A read returns `*_rsp_valid` for one clock, exactly one clock after it was accepted. Responses cannot be stalled, so the requester must take them. Writes give no response.

Top module: `cc_mailbox`

## Requirements
- R1: After reset, `on_time_o`, `late_o` and `cycle_mismatch_o` are low. Both sides read 0 at offsets 0x0 and 0x4, and the consumer reads cycle count 0 at 0x8.
- R2: Word offsets are 0x0 ready (bit 0), 0x4 timeout (bit 0; on the consumer side bit 1 is the mismatch status), 0x8 cycle number and 0xC payload. On the producer side, 0x8 and 0xC read back the staged cycle number and payload. On the consumer side, 0x8 reads the consumer cycle count and 0xC reads the delivered payload.
- R3: A producer write of bit 0 = 1 to 0x0 sets ready only if a payload write to 0xC was accepted earlier in the same logical cycle. Otherwise the write is ignored.
- R4: If ready is set when the deadline strobe is sampled, `on_time_o` is high for exactly the one clock after that edge, and the consumer's 0xC then returns the staged payload.
- R5: If ready is clear when the deadline strobe is sampled, `late_o` is high for one clock and the timeout flag (0x4 bit 0) reads 1 on both sides.
- R6: While timeout is set, producer writes to 0x0, 0x8 and 0xC are ignored until the next cycle start, so no ready reaches the consumer in that cycle.
- R7: If a producer ready write and the deadline strobe fall in the same clock, the packet is judged late.
- R8: A consumer read of 0xC clears ready. A cycle-start strobe clears ready, timeout and the staged state, and increments the consumer cycle count.
- R9: When a packet is delivered on time and its cycle number differs from the consumer cycle count, `cycle_mismatch_o` is set and stays set through later cycles. A consumer write of 1 to 0x4 bit 1 clears it, and a new mismatch in the same clock wins over the clear.
- R10: Only the first deadline in a logical cycle is judged, and later ones give no pulse. A deadline that coincides with a cycle start is dropped.
- R11: `*_req_ready` is always high, and a read is answered with `*_rsp_valid` one clock after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start_i | input | 1 | Consumer timebase: a new logical cycle begins |
| deadline_i | input | 1 | Consumer timebase: delivery deadline of the current cycle |
| p_req_valid | input | 1 | Producer request valid |
| p_req_ready | output | 1 | Producer request ready (always high) |
| p_req_write | input | 1 | Producer request is a write |
| p_req_addr | input | 4 | Producer byte offset |
| p_req_wdata | input | 32 | Producer write data |
| p_rsp_valid | output | 1 | Producer read response valid |
| p_rsp_rdata | output | 32 | Producer read data |
| c_req_valid | input | 1 | Consumer request valid |
| c_req_ready | output | 1 | Consumer request ready (always high) |
| c_req_write | input | 1 | Consumer request is a write |
| c_req_addr | input | 4 | Consumer byte offset |
| c_req_wdata | input | 32 | Consumer write data |
| c_rsp_valid | output | 1 | Consumer read response valid |
| c_rsp_rdata | output | 32 | Consumer read data |
| on_time_o | output | 1 | Pulse: packet judged on time |
| late_o | output | 1 | Pulse: packet judged late |
| cycle_mismatch_o | output | 1 | Sticky cycle-alignment error |

## Verification
The assertions check on every clock the invariants between the flags. The verdict pulses never fire together. A late verdict always comes with the timeout flag. Ready cannot rise without a staged payload and cannot appear while timeout holds. A cycle start leaves both flags low. The mismatch bit stays set until it is cleared. Read responses always arrive one clock after the request. The bench scenarios show the things that depend on sequences across both ports: the payload that actually reaches the consumer, the dropping of writes after an abandon, the tie-break between a ready write and the deadline, the judging of only the first deadline, and the comparison of the cycle numbers.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_AW   = 4;
  localparam int MBX_DW   = 32;
  localparam int MBX_NREG = 2 ** (MBX_AW - 2);
  localparam int MBX_CYW  = 16;

  localparam int REG_RDY = 0;
  localparam int REG_TMO = 1;
  localparam int REG_CYC = 2;
  localparam int REG_PAY = 3;
endpackage

// File: rtl/mbx_bus_slave.sv
module mbx_bus_slave
  import mbx_pkg::*;
#(
  parameter int AW = MBX_AW,
  parameter int DW = MBX_DW,
  localparam int NREG = 2 ** (AW - 2)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [AW-1:0]            req_addr,
  input  logic [DW-1:0]            req_wdata,
  output logic                     rsp_valid,
  output logic [DW-1:0]            rsp_rdata,
  input  logic [NREG-1:0][DW-1:0]  rd_words,
  output logic [NREG-1:0]          wr_stb,
  output logic [NREG-1:0]          rd_stb,
  output logic [DW-1:0]            wdata
);
  logic accept;
  logic [AW-3:0] widx;

  assign req_ready = 1'b1;
  assign accept    = req_valid && req_ready;
  assign widx      = req_addr[AW-1:2];
  assign wdata     = req_wdata;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign wr_stb[g] = accept &&  req_write && (widx == g[AW-3:0]);
    assign rd_stb[g] = accept && !req_write && (widx == g[AW-3:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept && !req_write;
      if (accept && !req_write) rsp_rdata <= rd_words[widx];
    end
  end

  p_rsp_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  p_no_rsp_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_write) |=> !rsp_valid);
endmodule

// File: rtl/mbx_stage.sv
module mbx_stage
  import mbx_pkg::*;
#(
  parameter int DW  = MBX_DW,
  parameter int CYW = MBX_CYW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cyc_start,
  input  logic           accept_en,
  input  logic           pay_wr,
  input  logic           cyc_wr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  pay_q,
  output logic [CYW-1:0] pcyc_q,
  output logic           staged_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pay_q    <= '0;
      pcyc_q   <= '0;
      staged_q <= 1'b0;
    end else if (cyc_start) begin
      staged_q <= 1'b0;
    end else if (accept_en) begin
      if (pay_wr) begin
        pay_q    <= wdata;
        staged_q <= 1'b1;
      end
      if (cyc_wr) pcyc_q <= wdata[CYW-1:0];
    end
  end

  p_stage_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_en && !cyc_start) |=> $stable(pay_q) && $stable(pcyc_q));
endmodule

// File: rtl/mbx_verdict.sv
module mbx_verdict
  import mbx_pkg::*;
#(
  parameter int DW  = MBX_DW,
  parameter int CYW = MBX_CYW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cyc_start,
  input  logic           deadline,
  input  logic           set_req,
  input  logic           staged,
  input  logic [DW-1:0]  pay,
  input  logic [CYW-1:0] pcyc,
  input  logic           cons_take,
  input  logic           mm_clr,
  output logic           ready_q,
  output logic           timeout_q,
  output logic           closed_q,
  output logic [DW-1:0]  deliver_q,
  output logic [CYW-1:0] ccyc_q,
  output logic           on_time_q,
  output logic           late_q,
  output logic           mismatch_q
);
  logic judge, hit, miss, mm_set, ready_set;

  assign judge     = deadline && !cyc_start && !closed_q;
  assign hit       = judge && ready_q;
  assign miss      = judge && !ready_q;
  assign mm_set    = hit && (pcyc != ccyc_q);
  assign ready_set = set_req && staged && !timeout_q && !closed_q && !deadline;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      timeout_q <= 1'b0;
      closed_q  <= 1'b0;
      deliver_q <= '0;
      ccyc_q    <= '0;
      on_time_q <= 1'b0;
      late_q    <= 1'b0;
    end else begin
      on_time_q <= hit;
      late_q    <= miss;
      if (cyc_start) begin
        ready_q   <= 1'b0;
        timeout_q <= 1'b0;
        closed_q  <= 1'b0;
        ccyc_q    <= ccyc_q + 1'b1;
      end else begin
        if (judge) closed_q <= 1'b1;
        if (miss) timeout_q <= 1'b1;
        if (hit) deliver_q <= pay;
        if (cons_take) ready_q <= 1'b0;
        else if (ready_set) ready_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mismatch_q <= 1'b0;
    else if (mm_set) mismatch_q <= 1'b1;
    else if (mm_clr) mismatch_q <= 1'b0;
  end

  p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(on_time_q && late_q));
  p_late_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    late_q |-> timeout_q);
  p_ready_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_q && !cyc_start) |=> !ready_q);
  p_ready_staged_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> staged);
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> (!ready_q && !timeout_q));
  p_mm_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch_q && !mm_clr) |=> mismatch_q);
endmodule

// File: rtl/cc_mailbox.sv
module cc_mailbox
  import mbx_pkg::*;
#(
  parameter int AW  = MBX_AW,
  parameter int DW  = MBX_DW,
  parameter int CYW = MBX_CYW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_start_i,
  input  logic          deadline_i,
  input  logic          p_req_valid,
  output logic          p_req_ready,
  input  logic          p_req_write,
  input  logic [AW-1:0] p_req_addr,
  input  logic [DW-1:0] p_req_wdata,
  output logic          p_rsp_valid,
  output logic [DW-1:0] p_rsp_rdata,
  input  logic          c_req_valid,
  output logic          c_req_ready,
  input  logic          c_req_write,
  input  logic [AW-1:0] c_req_addr,
  input  logic [DW-1:0] c_req_wdata,
  output logic          c_rsp_valid,
  output logic [DW-1:0] c_rsp_rdata,
  output logic          on_time_o,
  output logic          late_o,
  output logic          cycle_mismatch_o
);
  localparam int NREG = 2 ** (AW - 2);

  logic [NREG-1:0][DW-1:0] p_words, c_words;
  logic [NREG-1:0] p_wr, p_rd, c_wr, c_rd;
  logic [DW-1:0]  p_wd, c_wd;
  logic [DW-1:0]  pay_q, deliver_q;
  logic [CYW-1:0] pcyc_q, ccyc_q;
  logic staged_q, ready_q, timeout_q, closed_q, mismatch_q;
  logic accept_en;

  mbx_bus_slave #(.AW(AW), .DW(DW)) u_pbus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(p_req_valid), .req_ready(p_req_ready), .req_write(p_req_write),
    .req_addr(p_req_addr), .req_wdata(p_req_wdata),
    .rsp_valid(p_rsp_valid), .rsp_rdata(p_rsp_rdata),
    .rd_words(p_words), .wr_stb(p_wr), .rd_stb(p_rd), .wdata(p_wd)
  );

  mbx_bus_slave #(.AW(AW), .DW(DW)) u_cbus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(c_req_valid), .req_ready(c_req_ready), .req_write(c_req_write),
    .req_addr(c_req_addr), .req_wdata(c_req_wdata),
    .rsp_valid(c_rsp_valid), .rsp_rdata(c_rsp_rdata),
    .rd_words(c_words), .wr_stb(c_wr), .rd_stb(c_rd), .wdata(c_wd)
  );

  assign accept_en = !timeout_q && !closed_q;

  mbx_stage #(.DW(DW), .CYW(CYW)) u_stage (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start_i), .accept_en(accept_en),
    .pay_wr(p_wr[REG_PAY]), .cyc_wr(p_wr[REG_CYC]), .wdata(p_wd),
    .pay_q(pay_q), .pcyc_q(pcyc_q), .staged_q(staged_q)
  );

  mbx_verdict #(.DW(DW), .CYW(CYW)) u_verdict (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start_i), .deadline(deadline_i),
    .set_req(p_wr[REG_RDY] && p_wd[0]), .staged(staged_q), .pay(pay_q),
    .pcyc(pcyc_q), .cons_take(c_rd[REG_PAY]), .mm_clr(c_wr[REG_TMO] && c_wd[1]),
    .ready_q(ready_q), .timeout_q(timeout_q), .closed_q(closed_q),
    .deliver_q(deliver_q), .ccyc_q(ccyc_q), .on_time_q(on_time_o),
    .late_q(late_o), .mismatch_q(mismatch_q)
  );

  assign cycle_mismatch_o = mismatch_q;

  always_comb begin
    p_words          = '0;
    p_words[REG_RDY] = {{(DW-1){1'b0}}, ready_q};
    p_words[REG_TMO] = {{(DW-1){1'b0}}, timeout_q};
    p_words[REG_CYC] = {{(DW-CYW){1'b0}}, pcyc_q};
    p_words[REG_PAY] = pay_q;
    c_words          = '0;
    c_words[REG_RDY] = {{(DW-1){1'b0}}, ready_q};
    c_words[REG_TMO] = {{(DW-2){1'b0}}, mismatch_q, timeout_q};
    c_words[REG_CYC] = {{(DW-CYW){1'b0}}, ccyc_q};
    c_words[REG_PAY] = deliver_q;
  end
endmodule

// File: tb/cc_mailbox_tb_top.sv
module cc_mailbox_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start_i = 1'b0, deadline_i = 1'b0;
  logic p_req_valid = 1'b0, p_req_write = 1'b0;
  logic [3:0] p_req_addr = '0;
  logic [31:0] p_req_wdata = '0;
  logic c_req_valid = 1'b0, c_req_write = 1'b0;
  logic [3:0] c_req_addr = '0;
  logic [31:0] c_req_wdata = '0;
  logic p_req_ready, c_req_ready, p_rsp_valid, c_rsp_valid;
  logic [31:0] p_rsp_rdata, c_rsp_rdata;
  logic on_time_o, late_o, cycle_mismatch_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cc_mailbox dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_start_i(cyc_start_i), .deadline_i(deadline_i),
    .p_req_valid(p_req_valid), .p_req_ready(p_req_ready), .p_req_write(p_req_write),
    .p_req_addr(p_req_addr), .p_req_wdata(p_req_wdata),
    .p_rsp_valid(p_rsp_valid), .p_rsp_rdata(p_rsp_rdata),
    .c_req_valid(c_req_valid), .c_req_ready(c_req_ready), .c_req_write(c_req_write),
    .c_req_addr(c_req_addr), .c_req_wdata(c_req_wdata),
    .c_rsp_valid(c_rsp_valid), .c_rsp_rdata(c_rsp_rdata),
    .on_time_o(on_time_o), .late_o(late_o), .cycle_mismatch_o(cycle_mismatch_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pwr(logic [3:0] a, logic [31:0] d);
    p_req_valid = 1; p_req_write = 1; p_req_addr = a; p_req_wdata = d;
    @(negedge clk);
    p_req_valid = 0; p_req_write = 0;
  endtask

  task automatic cwr(logic [3:0] a, logic [31:0] d);
    c_req_valid = 1; c_req_write = 1; c_req_addr = a; c_req_wdata = d;
    @(negedge clk);
    c_req_valid = 0; c_req_write = 0;
  endtask

  task automatic prd(logic [3:0] a, output logic [31:0] d);
    p_req_valid = 1; p_req_write = 0; p_req_addr = a;
    @(negedge clk);
    p_req_valid = 0;
    chk("R11 producer rsp_valid", {31'b0, p_rsp_valid}, 32'd1);
    d = p_rsp_rdata;
  endtask

  task automatic crd(logic [3:0] a, output logic [31:0] d);
    c_req_valid = 1; c_req_write = 0; c_req_addr = a;
    @(negedge clk);
    c_req_valid = 0;
    d = c_rsp_rdata;
  endtask

  task automatic start_cycle();
    cyc_start_i = 1; @(negedge clk); cyc_start_i = 0;
  endtask

  // deadline pulse; returns {on_time, late} visible after the edge
  task automatic hit_deadline(output logic [1:0] v);
    deadline_i = 1; @(negedge clk); deadline_i = 0;
    v = {on_time_o, late_o};
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 outputs idle", {29'b0, on_time_o, late_o, cycle_mismatch_o}, 0);
    chk("R11 req_ready high", {30'b0, p_req_ready, c_req_ready}, 32'd3);
    crd(4'h0, d); chk("R1 consumer ready", d, 0);
    crd(4'h4, d); chk("R1 consumer timeout", d, 0);
    crd(4'h8, d); chk("R1 consumer cycle", d, 0);
    prd(4'h4, d); chk("R1 producer timeout", d, 0);
  endtask

  task automatic t_ontime();
    logic [31:0] d; logic [1:0] v;
    start_cycle();
    pwr(4'h8, 32'd1); pwr(4'hC, 32'hA5A5_0001); pwr(4'h0, 32'd1);
    prd(4'hC, d); chk("R2 producer payload readback", d, 32'hA5A5_0001);
    prd(4'h8, d); chk("R2 producer cycle readback", d, 32'd1);
    crd(4'h0, d); chk("R2 consumer ready before deadline", d, 1);
    hit_deadline(v); chk("R4 on-time pulse", {30'b0, v}, 32'd2);
    @(negedge clk); chk("R4 pulse one clock", {30'b0, on_time_o, late_o}, 0);
    crd(4'hC, d); chk("R4 delivered payload", d, 32'hA5A5_0001);
    crd(4'h0, d); chk("R8 read clears ready", d, 0);
    chk("R9 no mismatch when aligned", {31'b0, cycle_mismatch_o}, 0);
  endtask

  task automatic t_no_stage();
    logic [31:0] d; logic [1:0] v;
    start_cycle();
    pwr(4'h0, 32'd1);
    crd(4'h0, d); chk("R3 ready without payload ignored", d, 0);
    hit_deadline(v); chk("R5 late pulse", {30'b0, v}, 32'd1);
    prd(4'h4, d); chk("R5 producer sees timeout", d, 1);
    crd(4'h4, d); chk("R5 consumer sees timeout", d, 1);
    pwr(4'hC, 32'hDEAD_BEEF); pwr(4'h0, 32'd1);
    crd(4'h0, d); chk("R6 ready after timeout dropped", d, 0);
    prd(4'hC, d); chk("R6 payload after timeout dropped", d, 32'hA5A5_0001);
    start_cycle();
    crd(4'h4, d); chk("R8 start clears timeout", d, 0);
    crd(4'h8, d); chk("R8 consumer cycle count", d, 32'd3);
  endtask

  task automatic t_collide();
    logic [1:0] v;
    pwr(4'h8, 32'd3); pwr(4'hC, 32'h0000_0C0C);
    p_req_valid = 1; p_req_write = 1; p_req_addr = 4'h0; p_req_wdata = 32'd1;
    deadline_i = 1;
    @(negedge clk);
    p_req_valid = 0; p_req_write = 0; deadline_i = 0;
    v = {on_time_o, late_o};
    chk("R7 collision judged late", {30'b0, v}, 32'd1);
  endtask

  task automatic t_mismatch();
    logic [31:0] d; logic [1:0] v;
    start_cycle();   // consumer cycle 4
    pwr(4'h8, 32'd7); pwr(4'hC, 32'h0000_4444); pwr(4'h0, 32'd1);
    hit_deadline(v); chk("R9 delivered on time", {30'b0, v}, 32'd2);
    chk("R9 mismatch raised", {31'b0, cycle_mismatch_o}, 1);
    crd(4'h4, d); chk("R9 mismatch status bit", d, 32'd2);
    start_cycle();   // consumer cycle 5
    pwr(4'h8, 32'd5); pwr(4'hC, 32'h0000_5555); pwr(4'h0, 32'd1);
    hit_deadline(v);
    chk("R9 mismatch sticky", {31'b0, cycle_mismatch_o}, 1);
    cwr(4'h4, 32'd2);
    chk("R9 write-one clears", {31'b0, cycle_mismatch_o}, 0);
  endtask

  task automatic t_deadlines();
    logic [1:0] v; logic [31:0] d;
    start_cycle();
    hit_deadline(v); chk("R10 first deadline late", {30'b0, v}, 32'd1);
    hit_deadline(v); chk("R10 second deadline silent", {30'b0, v}, 0);
    cyc_start_i = 1; deadline_i = 1;
    @(negedge clk);
    cyc_start_i = 0; deadline_i = 0;
    chk("R10 deadline on start dropped", {30'b0, on_time_o, late_o}, 0);
    crd(4'h4, d); chk("R10 no timeout after dropped deadline", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ontime();
    t_no_stage();
    t_collide();
    t_mismatch();
    t_deadlines();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule